// File: doc/BRIEF.md
# Field Memory Power-Up Initialization Sequencer

This block drives the start-up sequence of a serial field delay memory whose write and read address pointers hold no valid value after power is applied. Once an external indication says the supply has settled, the sequencer waits a programmable settling interval and then runs the two memory ports through their bring-up patterns at the same time. Each port gets a burst of gated dummy clock cycles and a pointer-reset strobe. The reset strobe is always issued while the port clock runs, because the memory captures a reset on a clock edge.

Two patterns are available. The normal pattern gives a burst of dummy clocks, then one reset strobe, then two clocked cycles with the strobe low. The recovery pattern is for the case where the dummy cycles may have started before the supply settled. It gives a reset strobe, two quiet clocked cycles, the dummy burst, a second reset strobe and two more quiet clocked cycles. When both ports have finished, a ready flag rises. A restart pulse runs the whole sequence again from the settling interval. A loss of supply abandons the sequence at once.

All inputs and outputs belong to one system clock domain. The clock-enable outputs are meant to gate the memory's write and read clocks. The strobe outputs drive its pointer-reset pins.

Top module: `field_mem_init_seq`

## Requirements
- R1: While `rst` is high, and in the cycle after any clock edge that samples `rst` high, all five outputs are low.
- R2: While `supply_ok` is low, the sequencer waits and all outputs stay low. A clock edge that samples `supply_ok` low abandons any sequence in progress and drives all outputs low in the following cycle.
- R3: Take the clock edge at which `supply_ok` is first sampled high, or at which `restart` is sampled high. The clock enables first go high in the cycle after the STAB_CYCLES+1-th following edge. Until then, every output is low.
- R4: Normal pattern, per port, with N dummy cycles. The clock enable is high for N cycles with the strobe low. Then it is high for one cycle with the strobe high. Then it is high for two cycles with the strobe low. After that the enable is low.
- R5: A dummy-cycle parameter below 130 behaves as 130. A value at or above 130 is used as given.
- R6: The write port and the read port begin their patterns in the same cycle and run independently. Their lengths may differ.
- R7: Recovery pattern, per port, when `recover_mode` is high. The sequence is: one cycle with enable and strobe high; two cycles with enable high and strobe low; N dummy cycles; one cycle with enable and strobe high; two cycles with enable high and strobe low. After that the enable is low.
- R8: `recover_mode` is sampled only at the clock edge where a port begins its pattern. Changes to it later in the sequence have no effect on the outputs.
- R9: `init_done` rises in the first cycle in which both ports have finished their patterns. It stays high until a restart, a supply loss or a reset. While it is high, both clock enables and both strobes are low.
- R10: A `restart` pulse sampled while `supply_ok` is high clears `init_done` and all enables in the next cycle. The sequence then runs again, timed as in R3.
- R11: After a strobe cycle, that strobe stays low for at least the next two cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| supply_ok | input | 1 | High when the memory supply is stable |
| recover_mode | input | 1 | Selects the recovery pattern when high |
| restart | input | 1 | One-cycle request to rerun the full sequence |
| wclk_en | output | 1 | Gate for the memory write clock |
| rclk_en | output | 1 | Gate for the memory read clock |
| wptr_rst | output | 1 | Write-pointer reset strobe |
| rptr_rst | output | 1 | Read-pointer reset strobe |
| init_done | output | 1 | Both ports initialized |

## Verification
A supply loss, a restart or a reset shows its effect in the cycle right after the clock edge that samples it. The first dummy clock appears STAB_CYCLES+1 edges after the starting edge. Each later phase of a port pattern follows a fixed cycle offset from the port's first active cycle. The driver therefore pushes one expected output vector per clock edge, computed from these offsets. The monitor pops that vector one time unit after the same edge, so each comparison lands exactly on the cycle the result is due. The runs cover both patterns, write and read ports of unequal length, a clamped read count, a mode change in the middle of a sequence, and sequences cut short by a supply drop, a restart and a reset.

// File: rtl/fmi_pkg.sv
`timescale 1ns/1ps
package fmi_pkg;

    // smallest dummy burst the memory accepts on each port
    localparam int MIN_DUMMY  = 130;
    // quiet clocked cycles that follow every pointer-reset strobe
    localparam int GAP_CYCLES = 2;

    typedef enum logic [1:0] {
        TOP_WAIT,
        TOP_STAB,
        TOP_RUN
    } top_state_e;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_LEAD_RST,
        PH_LEAD_GAP,
        PH_DUMMY,
        PH_RST,
        PH_GAP,
        PH_DONE
    } port_phase_e;

    typedef struct packed {
        logic clk_en;
        logic ptr_rst;
        logic done;
    } port_out_t;

    function automatic int clamp_dummy(input int n);
        return (n < MIN_DUMMY) ? MIN_DUMMY : n;
    endfunction

endpackage

// File: rtl/fmi_stab_timer.sv
`timescale 1ns/1ps
module fmi_stab_timer #(
    parameter int STAB_CYCLES = 20_000_000
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    output logic elapsed
);
    localparam int TW = (STAB_CYCLES < 2) ? 1 : $clog2(STAB_CYCLES + 1);

    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign elapsed = (cnt_q == TW'(STAB_CYCLES - 1));

endmodule

// File: rtl/fmi_port_seq.sv
`timescale 1ns/1ps
module fmi_port_seq
    import fmi_pkg::*;
#(
    parameter int DUMMY_CYCLES = MIN_DUMMY
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      go,
    input  logic      recover,
    output port_out_t pout
);
    localparam int N  = clamp_dummy(DUMMY_CYCLES);
    localparam int CW = $clog2(N + 1);

    port_phase_e   phase_q;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !go) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
        end else begin
            unique case (phase_q)
                PH_IDLE: begin
                    // mode is taken here once and never looked at again
                    phase_q <= recover ? PH_LEAD_RST : PH_DUMMY;
                    cnt_q   <= '0;
                end
                PH_LEAD_RST: begin
                    phase_q <= PH_LEAD_GAP;
                    cnt_q   <= '0;
                end
                PH_LEAD_GAP: begin
                    if (cnt_q == CW'(GAP_CYCLES - 1)) begin
                        phase_q <= PH_DUMMY;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                PH_DUMMY: begin
                    if (cnt_q == CW'(N - 1)) begin
                        phase_q <= PH_RST;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                PH_RST: begin
                    phase_q <= PH_GAP;
                    cnt_q   <= '0;
                end
                PH_GAP: begin
                    if (cnt_q == CW'(GAP_CYCLES - 1)) begin
                        phase_q <= PH_DONE;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                PH_DONE: begin
                    phase_q <= PH_DONE;
                end
                default: begin
                    phase_q <= PH_IDLE;
                    cnt_q   <= '0;
                end
            endcase
        end
    end

    always_comb begin
        pout.clk_en  = (phase_q == PH_LEAD_RST) || (phase_q == PH_LEAD_GAP) ||
                       (phase_q == PH_DUMMY)    || (phase_q == PH_RST)      ||
                       (phase_q == PH_GAP);
        pout.ptr_rst = (phase_q == PH_LEAD_RST) || (phase_q == PH_RST);
        pout.done    = (phase_q == PH_DONE);
    end

endmodule

// File: rtl/field_mem_init_seq.sv
`timescale 1ns/1ps
module field_mem_init_seq
    import fmi_pkg::*;
#(
    parameter int STAB_CYCLES     = 20_000_000,
    parameter int WR_DUMMY_CYCLES = 130,
    parameter int RD_DUMMY_CYCLES = 130
) (
    input  logic clk,
    input  logic rst,
    input  logic supply_ok,
    input  logic recover_mode,
    input  logic restart,
    output logic wclk_en,
    output logic rclk_en,
    output logic wptr_rst,
    output logic rptr_rst,
    output logic init_done
);
    localparam int NUM_PORTS = 2;

    top_state_e state_q;
    logic       elapsed;
    logic       tmr_clear;
    logic       run;
    port_out_t  pout [NUM_PORTS];

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= TOP_WAIT;
        end else if (!supply_ok) begin
            state_q <= TOP_WAIT;
        end else if (restart) begin
            state_q <= TOP_STAB;
        end else begin
            unique case (state_q)
                TOP_WAIT: state_q <= TOP_STAB;
                TOP_STAB: if (elapsed) state_q <= TOP_RUN;
                TOP_RUN:  state_q <= TOP_RUN;
                default:  state_q <= TOP_WAIT;
            endcase
        end
    end

    assign tmr_clear = (state_q != TOP_STAB) || restart || !supply_ok;
    assign run       = (state_q == TOP_RUN);

    fmi_stab_timer #(
        .STAB_CYCLES(STAB_CYCLES)
    ) u_timer (
        .clk    (clk),
        .rst    (rst),
        .clear  (tmr_clear),
        .elapsed(elapsed)
    );

    for (genvar g = 0; g < NUM_PORTS; g++) begin : g_port
        localparam int NDUM = (g == 0) ? WR_DUMMY_CYCLES : RD_DUMMY_CYCLES;
        fmi_port_seq #(
            .DUMMY_CYCLES(NDUM)
        ) u_seq (
            .clk    (clk),
            .rst    (rst),
            .go     (run),
            .recover(recover_mode),
            .pout   (pout[g])
        );
    end

    // outputs drop in the same cycle the run state is left
    assign wclk_en   = run && pout[0].clk_en;
    assign rclk_en   = run && pout[1].clk_en;
    assign wptr_rst  = run && pout[0].ptr_rst;
    assign rptr_rst  = run && pout[1].ptr_rst;
    assign init_done = run && pout[0].done && pout[1].done;

endmodule

// File: rtl/field_mem_init_seq_chk.sv
`timescale 1ns/1ps
module field_mem_init_seq_chk (
    input logic clk,
    input logic rst,
    input logic supply_ok,
    input logic restart,
    input logic wclk_en,
    input logic rclk_en,
    input logic wptr_rst,
    input logic rptr_rst,
    input logic init_done
);
    logic any_out;
    assign any_out = wclk_en | rclk_en | wptr_rst | rptr_rst | init_done;

    // R1
    reset_quiet_chk: assert property (@(posedge clk) rst |=> !any_out);

    // R2
    supply_drop_chk: assert property (@(posedge clk) disable iff (rst)
        !supply_ok |=> !any_out);

    // R4
    wstrobe_clocked_chk: assert property (@(posedge clk) disable iff (rst)
        wptr_rst |-> wclk_en);

    // R4
    rstrobe_clocked_chk: assert property (@(posedge clk) disable iff (rst)
        rptr_rst |-> rclk_en);

    // R9
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        init_done |-> !(wclk_en | rclk_en | wptr_rst | rptr_rst));

    // R10
    restart_clears_chk: assert property (@(posedge clk) disable iff (rst)
        restart |=> !init_done && !wclk_en && !rclk_en);

    // R11
    wgap_one_chk: assert property (@(posedge clk) disable iff (rst)
        wptr_rst |=> !wptr_rst);

    // R11
    wgap_two_chk: assert property (@(posedge clk) disable iff (rst)
        $past(wptr_rst, 2) |-> !wptr_rst);

    // R11
    rgap_one_chk: assert property (@(posedge clk) disable iff (rst)
        rptr_rst |=> !rptr_rst);

    // R11
    rgap_two_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rptr_rst, 2) |-> !rptr_rst);

endmodule

bind field_mem_init_seq field_mem_init_seq_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .supply_ok(supply_ok),
    .restart  (restart),
    .wclk_en  (wclk_en),
    .rclk_en  (rclk_en),
    .wptr_rst (wptr_rst),
    .rptr_rst (rptr_rst),
    .init_done(init_done)
);

// File: tb/field_mem_init_seq_bench.sv
`timescale 1ns/1ps
module field_mem_init_seq_bench;

    localparam int S     = 40;
    localparam int WR_N  = 150;
    localparam int RD_P  = 100;           // below minimum on purpose
    localparam int RD_N  = 130;           // value the design must apply (R5)
    localparam int TLEN  = 162;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic supply_ok = 1'b0;
    logic recover_mode = 1'b0;
    logic restart = 1'b0;
    logic wclk_en, rclk_en, wptr_rst, rptr_rst, init_done;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    logic [4:0] exp_q [$];
    string      req_q [$];

    always #2.5 clk = ~clk;

    field_mem_init_seq #(
        .STAB_CYCLES    (S),
        .WR_DUMMY_CYCLES(WR_N),
        .RD_DUMMY_CYCLES(RD_P)
    ) u_field_mem_init_seq (
        .clk         (clk),
        .rst         (rst),
        .supply_ok   (supply_ok),
        .recover_mode(recover_mode),
        .restart     (restart),
        .wclk_en     (wclk_en),
        .rclk_en     (rclk_en),
        .wptr_rst    (wptr_rst),
        .rptr_rst    (rptr_rst),
        .init_done   (init_done)
    );

    // {clk_en, ptr_rst, done} of one port, t cycles after it starts
    function automatic logic [2:0] port_exp(input bit rec, input int n, input int t);
        if (!rec) begin
            if (t < n)      return 3'b100;
            if (t == n)     return 3'b110;
            if (t < n + 3)  return 3'b100;
            return 3'b001;
        end
        if (t == 0)         return 3'b110;
        if (t < 3 + n)      return 3'b100;
        if (t == 3 + n)     return 3'b110;
        if (t < 6 + n)      return 3'b100;
        return 3'b001;
    endfunction

    function automatic logic [4:0] full_exp(input bit rec, input int t);
        logic [2:0] w, r;
        w = port_exp(rec, WR_N, t);
        r = port_exp(rec, RD_N, t);
        return {w[2], r[2], w[1], r[1], w[0] & r[0]};
    endfunction

    // driver: set inputs for the coming edge and queue what must follow it
    task automatic step(input logic r, input logic s_ok, input logic rec,
                        input logic rs, input logic [4:0] exp, input string req);
        @(negedge clk);
        rst          = r;
        supply_ok    = s_ok;
        recover_mode = rec;
        restart      = rs;
        exp_q.push_back(exp);
        req_q.push_back(req);
    endtask

    task automatic run_seq(input bit rec, input bit rs, input bit flip, input int upto);
        // starting edge: supply seen high or restart seen
        step(1'b0, 1'b1, rec, rs, 5'b0, rs ? "R10" : "R3");
        for (int k = 0; k < S; k++)
            step(1'b0, 1'b1, rec, 1'b0, 5'b0, "R3");
        for (int t = 0; t < upto; t++) begin
            string tag;
            logic  drv;
            drv = (flip && t >= 5) ? ~rec : rec;
            if (flip && t >= 5)                 tag = "R8";
            else if (rec)                       tag = "R7";
            else if (t == 0)                    tag = "R6";
            else if (t >= RD_N && t < RD_N + 3) tag = "R5";
            else if (t >= WR_N + 3)             tag = "R9";
            else                                tag = "R4";
            step(1'b0, 1'b1, drv, 1'b0, full_exp(rec, t), tag);
        end
    endtask

    // monitor: compare one time unit after each edge
    always @(posedge clk) begin
        #1;
        if (exp_q.size() > 0) begin
            logic [4:0] e, a;
            string rq;
            e  = exp_q.pop_front();
            rq = req_q.pop_front();
            a  = {wclk_en, rclk_en, wptr_rst, rptr_rst, init_done};
            n_tests++;
            if (a !== e) begin
                n_fail++;
                $display("FAIL %s: got %b expected %b (wclk,rclk,wrst,rrst,done)", rq, a, e);
            end
        end
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        for (int i = 0; i < 4; i++) step(1'b1, 1'b0, 1'b0, 1'b0, 5'b0, "R1");
        // R2: no supply, nothing happens, restart ignored too
        for (int i = 0; i < 20; i++) step(1'b0, 1'b0, 1'b0, (i == 7), 5'b0, "R2");
        // normal pattern to completion
        run_seq(1'b0, 1'b0, 1'b0, TLEN);
        // R10: restart from done, normal again
        run_seq(1'b0, 1'b1, 1'b0, TLEN);
        // R7 and R8: recovery pattern, mode input flipped mid-run
        run_seq(1'b1, 1'b1, 1'b1, TLEN);
        // R2: supply drop in the middle of the dummy burst
        run_seq(1'b0, 1'b1, 1'b0, 60);
        for (int i = 0; i < 5; i++) step(1'b0, 1'b0, 1'b0, 1'b0, 5'b0, "R2");
        run_seq(1'b0, 1'b0, 1'b0, TLEN);
        // R10: restart in the middle of a recovery run
        run_seq(1'b1, 1'b1, 1'b0, 40);
        run_seq(1'b1, 1'b1, 1'b0, TLEN);
        // R1: reset in the middle of a run, supply kept high
        run_seq(1'b0, 1'b1, 1'b0, 50);
        for (int i = 0; i < 3; i++) step(1'b1, 1'b1, 1'b0, 1'b0, 5'b0, "R1");
        run_seq(1'b0, 1'b0, 1'b0, TLEN);

        wait (exp_q.size() == 0);
        #10;
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule